// File: doc/BRIEF.md
# Single-Shot Error Insertion Controller

This block sits beside a transmit framer and converts a manual trigger into single error-insertion strobes. The trigger comes either from a software control bit or from an external manual-insert pin; a source-select input picks which one is live. A rising edge on the selected source arms one pending request. The request is released as a one-cycle insert pulse in the first cycle where the framer datapath raises its insertion-opportunity strobe. That pulse is fanned out into one strobe per error type, gated by a per-type enable vector, so the framer corrupts only the types that are currently enabled.

Requests do not queue: any number of rising edges between two opportunities collapse into a single error. A level held high never produces a second error; the source has to fall and rise again. The external pin is asynchronous and passes through a synchronizer before it reaches the source mux. Because the edge detector watches the output of the mux, switching the select onto a source that is already high counts as a rising edge.

All inputs other than the pin are synchronous to `clk`. Control pins are plain levels and strobes; the block has no streaming data path and so no valid/ready handshake.

Top module: `err_shot_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `insert_pulse` and every bit of `type_ins` are 0, and no request is pending (an opportunity in the first cycle after reset gives no pulse).
- R2: With `src_sel` = 0, a 0-to-1 change of `sw_req` sampled at a clock edge arms one request; at the next cycle where `opp_strobe` is 1, `insert_pulse` is 1 for exactly that cycle.
- R3: A source level held high produces no further pulse at later opportunities; a new error needs the source to return to 0 and rise to 1 again.
- R4: Several rising edges of the selected source before an opportunity yield exactly one pulse at that opportunity and none at the following one.
- R5: With `src_sel` = 1 the request source is `ext_req`; activity on `sw_req` then has no effect on `insert_pulse`.
- R6: Changing `src_sel` while the newly selected source is already high arms a request, exactly as a rising edge of that source does.
- R7: During a pulse, `type_ins[i]` equals `type_en[i]` for each type i; outside a pulse all bits of `type_ins` are 0.
- R8: If `type_en` is all zero at an opportunity with a request pending, `insert_pulse` is still 1, `type_ins` is 0, and the request is consumed (no pulse at the next opportunity).
- R9: A rising edge seen in the same cycle that an opportunity consumes a pending request re-arms the request for the next opportunity.
- R10: `ext_req` passes through a two-flop synchronizer: a rise of `ext_req` first sampled at clock edge k is visible as an armed request from the cycle after edge k+2, and an opportunity in earlier cycles gives no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_sel | input | 1 | Request source select: 0 = `sw_req`, 1 = `ext_req` |
| sw_req | input | 1 | Software single-insert control bit (synchronous level) |
| ext_req | input | 1 | External manual-insert pin (asynchronous level) |
| opp_strobe | input | 1 | Insertion opportunity from the framer datapath |
| type_en | input | N_TYPES | Per-type error enables |
| insert_pulse | output | 1 | One-cycle strobe: a pending request is consumed this cycle |
| type_ins | output | N_TYPES | Per-type insert strobes (`insert_pulse` AND `type_en`) |

## Verification
The bench targets the collapse of repeated edges into one error, where a counter instead of a flag would emit a second pulse at the next opportunity, and the case of an edge landing in the very cycle a request is consumed, where a clear-wins update would silently lose the new request. It also checks that a held-high source never re-fires, which a level-sensitive detector would get wrong, and that switching the select onto a high pin arms a request, which a detector placed before the mux would miss. The synchronizer latency is checked cycle by cycle so that a missing or extra stage moves the pulse and is reported, and an all-disabled opportunity must still consume the request.

// File: rtl/err_shot_pkg.sv
package err_shot_pkg;
  typedef enum logic {
    SRC_SW  = 1'b0,
    SRC_PIN = 1'b1
  } src_sel_e;
endpackage

// File: rtl/esi_sync.sv
module esi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

  // R10: the input reaches the output no earlier than STAGES edges later
  assert_sync_delay_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(q) |-> $past(chain[0]) || (STAGES == 1));
endmodule

// File: rtl/esi_arm.sv
module esi_arm
  import err_shot_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  src_sel_e sel,
  input  logic     sw_lvl,
  input  logic     pin_lvl,
  input  logic     opp,
  output logic     pending,
  output logic     rise
);
  logic src;
  logic src_prev;
  logic pending_nxt;

  // Mux first, then detect: a select change onto a high source is an edge.
  assign src  = (sel == SRC_PIN) ? pin_lvl : sw_lvl;
  assign rise = src & ~src_prev;

  // A new edge wins over consumption so it survives for the next opportunity.
  assign pending_nxt = rise | (pending & ~opp);

  always_ff @(posedge clk) begin
    if (rst) begin
      src_prev <= 1'b0;
      pending  <= 1'b0;
    end else begin
      src_prev <= src;
      pending  <= pending_nxt;
    end
  end

  // R2: an edge always leaves a request armed
  assert_edge_arms_R2: assert property (@(posedge clk) disable iff (rst)
    rise |=> pending);
  // R3: a source that stayed high gives no edge
  assert_level_no_edge_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(src) && src) |-> !rise);
  // R4: a request waits, unchanged, until an opportunity
  assert_request_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (pending && !opp) |=> pending);
  // R8: consumption without a new edge empties the flag
  assert_consume_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (pending && opp && !rise) |=> !pending);
  // R9: an edge during consumption re-arms
  assert_rearm_R9: assert property (@(posedge clk) disable iff (rst)
    (pending && opp && rise) |=> pending);
endmodule

// File: rtl/esi_gate.sv
module esi_gate #(
  parameter int N_TYPES = 4
) (
  input  logic               pending,
  input  logic               opp,
  input  logic [N_TYPES-1:0] en,
  output logic               pulse,
  output logic [N_TYPES-1:0] ins
);
  assign pulse = pending & opp;

  generate
    for (genvar t = 0; t < N_TYPES; t++) begin : g_type
      assign ins[t] = pulse & en[t];
    end
  endgenerate

  // R7: a type strobe implies its enable
  always_comb begin
    assert_type_needs_en_R7: assert ((ins & ~en) == '0);
  end
endmodule

// File: rtl/err_shot_ctrl.sv
module err_shot_ctrl
  import err_shot_pkg::*;
#(
  parameter int N_TYPES     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               src_sel,
  input  logic               sw_req,
  input  logic               ext_req,
  input  logic               opp_strobe,
  input  logic [N_TYPES-1:0] type_en,
  output logic               insert_pulse,
  output logic [N_TYPES-1:0] type_ins
);
  logic     pin_sync;
  logic     pending;
  logic     rise;
  src_sel_e sel;

  assign sel = src_sel_e'(src_sel);

  esi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (ext_req),
    .q   (pin_sync)
  );

  esi_arm u_arm (
    .clk     (clk),
    .rst     (rst),
    .sel     (sel),
    .sw_lvl  (sw_req),
    .pin_lvl (pin_sync),
    .opp     (opp_strobe),
    .pending (pending),
    .rise    (rise)
  );

  esi_gate #(.N_TYPES(N_TYPES)) u_gate (
    .pending (pending),
    .opp     (opp_strobe),
    .en      (type_en),
    .pulse   (insert_pulse),
    .ins     (type_ins)
  );

  // R1: nothing fires in the first cycle out of reset
  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    $fell(rst) |-> !insert_pulse);
  // R2: a pulse needs the opportunity strobe
  assert_pulse_on_opp_R2: assert property (@(posedge clk) disable iff (rst)
    insert_pulse |-> opp_strobe);
  // R4: back-to-back pulses need a fresh edge in between
  assert_no_double_R4: assert property (@(posedge clk) disable iff (rst)
    (insert_pulse && !rise) |=> !insert_pulse);
endmodule

// File: tb/err_shot_ctrl_bench.sv
module err_shot_ctrl_bench;
  localparam int NT = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          src_sel, sw_req, ext_req, opp_strobe;
  logic [NT-1:0] type_en;
  logic          insert_pulse;
  logic [NT-1:0] type_ins;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  err_shot_ctrl #(.N_TYPES(NT), .SYNC_STAGES(2)) u_err_shot_ctrl (
    .clk(clk), .rst(rst), .src_sel(src_sel), .sw_req(sw_req),
    .ext_req(ext_req), .opp_strobe(opp_strobe), .type_en(type_en),
    .insert_pulse(insert_pulse), .type_ins(type_ins)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // advance one clock; inputs are driven 5 ns after the edge
  task automatic cyc();
    @(posedge clk);
    #5;
  endtask

  task automatic look(input string req, input int exp_pulse, input int exp_ins);
    #1;
    check({req, " pulse"}, int'(insert_pulse), exp_pulse);
    check({req, " types"}, int'(type_ins), exp_ins);
  endtask

  task automatic do_reset(input logic sel);
    rst = 1'b1; src_sel = sel; sw_req = 1'b0; ext_req = 1'b0;
    opp_strobe = 1'b0; type_en = '1;
    cyc(); cyc();
    rst = 1'b0;
  endtask

  task automatic t_reset_R1();
    rst = 1'b1; src_sel = 1'b0; sw_req = 1'b1; ext_req = 1'b1;
    opp_strobe = 1'b1; type_en = '1;
    cyc();
    look("R1 in reset", 0, 0);
    cyc();
    rst = 1'b0; sw_req = 1'b0; ext_req = 1'b0;
    look("R1 first cycle", 0, 0);
    cyc();
    look("R1 no leftover", 0, 0);
    opp_strobe = 1'b0;
  endtask

  task automatic t_single_R2();
    do_reset(1'b0);
    cyc(); sw_req = 1'b1;
    cyc(); opp_strobe = 1'b1;
    look("R2 pulse", 1, 15);
    cyc();
    look("R2 one cycle", 0, 0);
    opp_strobe = 1'b0;
  endtask

  task automatic t_hold_R3();
    do_reset(1'b0);
    sw_req = 1'b1;
    cyc(); opp_strobe = 1'b1;
    look("R3 first", 1, 15);
    cyc(); cyc();
    look("R3 held high", 0, 0);
    opp_strobe = 1'b0; sw_req = 1'b0;
    cyc(); sw_req = 1'b1;
    cyc(); opp_strobe = 1'b1;
    look("R3 re-rise", 1, 15);
    cyc(); opp_strobe = 1'b0;
  endtask

  task automatic t_collapse_R4();
    do_reset(1'b0);
    for (int i = 0; i < 3; i++) begin
      sw_req = 1'b1; cyc();
      sw_req = 1'b0; cyc();
    end
    opp_strobe = 1'b1;
    look("R4 single", 1, 15);
    cyc();
    look("R4 no second", 0, 0);
    opp_strobe = 1'b0;
  endtask

  task automatic t_pin_mode_R5();
    do_reset(1'b1);
    cyc(); sw_req = 1'b1;
    cyc(); sw_req = 1'b0;
    cyc(); opp_strobe = 1'b1;
    look("R5 sw ignored", 0, 0);
    opp_strobe = 1'b0;
    ext_req = 1'b1;
    cyc(); cyc(); cyc();
    opp_strobe = 1'b1;
    look("R5 pin fires", 1, 15);
    cyc(); opp_strobe = 1'b0;
  endtask

  task automatic t_select_R6();
    do_reset(1'b0);
    ext_req = 1'b1;
    cyc(); cyc(); cyc();
    opp_strobe = 1'b1;
    look("R6 before switch", 0, 0);
    opp_strobe = 1'b0;
    src_sel = 1'b1;
    cyc(); opp_strobe = 1'b1;
    look("R6 switch edge", 1, 15);
    cyc();
    look("R6 no repeat", 0, 0);
    opp_strobe = 1'b0;
  endtask

  task automatic t_types_R7();
    do_reset(1'b0);
    type_en = 4'b0101;
    sw_req = 1'b1;
    cyc(); opp_strobe = 1'b1;
    look("R7 mask 0101", 1, 5);
    opp_strobe = 1'b0; sw_req = 1'b0;
    cyc(); sw_req = 1'b1; type_en = 4'b1010;
    cyc();
    look("R7 idle", 0, 0);
    opp_strobe = 1'b1;
    look("R7 mask 1010", 1, 10);
    cyc(); opp_strobe = 1'b0;
  endtask

  task automatic t_none_R8();
    do_reset(1'b0);
    type_en = '0;
    sw_req = 1'b1;
    cyc(); opp_strobe = 1'b1;
    look("R8 disabled", 1, 0);
    cyc(); type_en = '1;
    look("R8 consumed", 0, 0);
    opp_strobe = 1'b0;
  endtask

  task automatic t_rearm_R9();
    do_reset(1'b0);
    sw_req = 1'b1;
    cyc(); sw_req = 1'b0;
    cyc(); sw_req = 1'b1; opp_strobe = 1'b1;
    look("R9 consume", 1, 15);
    cyc();
    look("R9 rearmed", 1, 15);
    cyc();
    look("R9 empty", 0, 0);
    opp_strobe = 1'b0;
  endtask

  task automatic t_sync_R10();
    do_reset(1'b1);
    cyc(); ext_req = 1'b1; opp_strobe = 1'b1;
    look("R10 before k", 0, 0);
    cyc();
    look("R10 after k", 0, 0);
    cyc();
    look("R10 after k+1", 0, 0);
    cyc();
    look("R10 after k+2", 1, 15);
    cyc(); opp_strobe = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset_R1();
    t_single_R2();
    t_hold_R3();
    t_collapse_R4();
    t_pin_mode_R5();
    t_select_R6();
    t_types_R7();
    t_none_R8();
    t_rearm_R9();
    t_sync_R10();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule